// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block holds the stores that an out-of-order core has dispatched but not yet written to memory. A store claims the entry at the queue tail when it is dispatched. It receives its address and data later, when it executes, in any order relative to other stores. It leaves the queue only when it retires: the oldest entry is then presented to the data cache as a write. Because memory writes cannot be undone, nothing reaches the cache before retirement, and stores drain strictly in program order.

Loads query the queue while the cache is read. A load presents its word address and the tail pointer it saw when it was dispatched. That snapshot fixes which stores are older than the load: every entry from the head up to, but not including, the snapshot. Among those older stores whose address matches, the youngest supplies the forwarded data. If none matches, a miss is reported and the cache value is used. The block also flags the case where some older store has not yet produced its address. With the `CONSERVATIVE` parameter set, a load is then held back; otherwise the load is always allowed to proceed and later violation checks are left to other logic.

Pointers carry one wrap bit above the index bits. This keeps full and empty distinct and keeps the age window correct when the pointers wrap. A flush empties the queue at once.

Top module: `store_fwd_queue`

## Requirements
- R1: After reset the queue is empty (`sq_empty`=1), `disp_ready`=1, `tail_ptr`=0, `wr_en`=0 and a probe reports no hit.
- R2: A dispatch takes the entry at `tail_ptr` (bits [IDX_W-1:0] are the entry index, bit IDX_W is the wrap bit) and advances the tail by one. When DEPTH stores are held, `disp_ready` is 0 and a dispatch leaves `tail_ptr` unchanged.
- R3: An execute writes `exe_addr` and `exe_data` into entry `exe_idx` and marks its address known. The entry can then be forwarded from and can retire.
- R4: With `ret_valid`=1 and the queue not empty, `wr_en` is 1 in that cycle with the head entry's address and data. The head then advances by one, so stores leave in dispatch order.
- R5: A probe treats as older exactly the entries from the head up to, but not including, `ld_pos`, counted modulo 2*DEPTH.
- R6: When one or more older entries with a known address equal `ld_addr`, `ld_hit`=1 and `ld_data` is the data of the youngest of them.
- R7: When no older entry matches, `ld_hit`=0. A matching entry at or after `ld_pos` is ignored.
- R8: `ld_unknown`=1 exactly when at least one older entry has not yet been executed.
- R9: With CONSERVATIVE=1, `ld_ok` equals the inverse of `ld_unknown`. With CONSERVATIVE=0, `ld_ok` is always 1.
- R10: A flush sets the tail equal to the head, makes `sq_empty`=1 in the next cycle and clears every entry. A store dispatched after the flush reads as not yet executed.
- R11: Age selection and forwarding stay correct after the head and tail have wrapped past the last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue |
| disp_valid | input | 1 | Dispatch one store this cycle |
| disp_ready | output | 1 | Queue has a free entry |
| tail_ptr | output | IDX_W+1 | Tail pointer with wrap bit; entry given to a dispatched store and snapshot for loads |
| exe_valid | input | 1 | A store executes this cycle |
| exe_idx | input | IDX_W | Entry of the executing store |
| exe_addr | input | ADDR_W | Word address of the executing store |
| exe_data | input | DATA_W | Data of the executing store |
| ret_valid | input | 1 | Retire the oldest store |
| wr_en | output | 1 | Cache write strobe |
| wr_addr | output | ADDR_W | Cache write address |
| wr_data | output | DATA_W | Cache write data |
| sq_empty | output | 1 | No store is held |
| ld_pos | input | IDX_W+1 | Tail snapshot taken at load dispatch |
| ld_addr | input | ADDR_W | Word address of the probing load |
| ld_hit | output | 1 | An older store forwards its data |
| ld_data | output | DATA_W | Forwarded data |
| ld_unknown | output | 1 | Some older store has no address yet |
| ld_ok | output | 1 | Load may complete under the configured policy |

## Verification
The assertions rely on the core using the queue correctly. An execute must target an entry that is allocated and not yet executed. A retire must only be issued once the head store has executed. The bench follows these rules: it executes only entries that its own model holds as allocated and unexecuted, and it executes every remaining store before it retires. Probes use only snapshots that lie between the model's head and tail, and the sweep moves the head through every entry position across several wraps.

// File: rtl/sqf_pkg.sv
package sqf_pkg;

   function automatic bit sqf_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/sqf_ptrs.sv
module sqf_ptrs #(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int PW = IDX_W + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          disp_valid,
   input  logic          ret_valid,
   output logic [PW-1:0] head_q,
   output logic [PW-1:0] tail_q,
   output logic          full,
   output logic          empty,
   output logic          disp_fire,
   output logic          ret_fire
);

   assign empty = (head_q == tail_q);
   assign full  = (head_q[IDX_W] != tail_q[IDX_W]) &&
                  (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]);
   assign disp_fire = disp_valid && !full && !flush;
   assign ret_fire  = ret_valid && !empty && !flush;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else if (flush) begin
         tail_q <= head_q;
      end else begin
         if (disp_fire) tail_q <= tail_q + PW'(1);
         if (ret_fire)  head_q <= head_q + PW'(1);
      end
   end

   // R2
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !flush) |=> (tail_q == $past(tail_q)));

   // R2
   occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (PW'(tail_q - head_q) <= PW'(DEPTH)));

   // R4
   retire_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_fire |=> (head_q == $past(head_q) + PW'(1)));

   // R10
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);

endmodule

// File: rtl/sqf_slots.sv
module sqf_slots #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic                          disp_fire,
   input  logic [IDX_W-1:0]              tail_idx,
   input  logic                          exe_valid,
   input  logic [IDX_W-1:0]              exe_idx,
   input  logic [ADDR_W-1:0]             exe_addr,
   input  logic [DATA_W-1:0]             exe_data,
   input  logic                          ret_fire,
   input  logic [IDX_W-1:0]              head_idx,
   output logic [DEPTH-1:0]              aval_q,
   output logic [DEPTH-1:0][ADDR_W-1:0]  addr_q,
   output logic [DEPTH-1:0][DATA_W-1:0]  data_q,
   output logic                          head_aval,
   output logic [ADDR_W-1:0]             head_addr,
   output logic [DATA_W-1:0]             head_data
);

   logic [DEPTH-1:0] valid_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         aval_q  <= '0;
      end else if (flush) begin
         valid_q <= '0;
         aval_q  <= '0;
      end else begin
         if (disp_fire) begin
            valid_q[tail_idx] <= 1'b1;
            aval_q[tail_idx]  <= 1'b0;
         end
         if (exe_valid) aval_q[exe_idx] <= 1'b1;
         if (ret_fire) begin
            valid_q[head_idx] <= 1'b0;
            aval_q[head_idx]  <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (exe_valid) begin
         addr_q[exe_idx] <= exe_addr;
         data_q[exe_idx] <= exe_data;
      end
   end

   assign head_aval = aval_q[head_idx];
   assign head_addr = addr_q[head_idx];
   assign head_data = data_q[head_idx];

   // R3
   exe_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exe_valid |-> (valid_q[exe_idx] && !aval_q[exe_idx]));

   // R3
   exe_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exe_valid && !flush) |=> aval_q[$past(exe_idx)]);

   // R10
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0 && aval_q == '0));

endmodule

// File: rtl/sqf_probe.sv
module sqf_probe #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int PW = IDX_W + 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [PW-1:0]                 head_q,
   input  logic [PW-1:0]                 ld_pos,
   input  logic [ADDR_W-1:0]             ld_addr,
   input  logic [DEPTH-1:0]              aval_q,
   input  logic [DEPTH-1:0][ADDR_W-1:0]  addr_q,
   input  logic [DEPTH-1:0][DATA_W-1:0]  data_q,
   output logic                          hit,
   output logic [DATA_W-1:0]             data,
   output logic                          unknown
);

   logic [PW-1:0]    n_older;
   logic [DEPTH-1:0] match_vec;

   assign n_older = ld_pos - head_q;

   // address comparators, one per entry
   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match_vec[g] = aval_q[g] && (addr_q[g] == ld_addr);
   end

   // walk from oldest to youngest; the last older match wins
   always_comb begin
      logic [IDX_W-1:0] phys;
      hit     = 1'b0;
      data    = '0;
      unknown = 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
         phys = head_q[IDX_W-1:0] + IDX_W'(k);
         if (PW'(k) < n_older) begin
            if (!aval_q[phys]) unknown = 1'b1;
            if (match_vec[phys]) begin
               hit  = 1'b1;
               data = data_q[phys];
            end
         end
      end
   end

   // R6
   hit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (n_older != '0));

   // R8
   unknown_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unknown |-> (n_older != '0));

endmodule

// File: rtl/store_fwd_queue.sv
module store_fwd_queue #(
   parameter int DEPTH        = 8,
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 32,
   parameter bit CONSERVATIVE = 1'b1,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int PW = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              disp_valid,
   output logic              disp_ready,
   output logic [PW-1:0]     tail_ptr,
   input  logic              exe_valid,
   input  logic [IDX_W-1:0]  exe_idx,
   input  logic [ADDR_W-1:0] exe_addr,
   input  logic [DATA_W-1:0] exe_data,
   input  logic              ret_valid,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              sq_empty,
   input  logic [PW-1:0]     ld_pos,
   input  logic [ADDR_W-1:0] ld_addr,
   output logic              ld_hit,
   output logic [DATA_W-1:0] ld_data,
   output logic              ld_unknown,
   output logic              ld_ok
);

   import sqf_pkg::*;

   initial begin : param_chk
      assert (sqf_is_pow2(DEPTH) && DEPTH >= 2)
         else $error("store_fwd_queue: DEPTH must be a power of two >= 2");
      assert (ADDR_W > 0 && DATA_W > 0)
         else $error("store_fwd_queue: widths must be positive");
   end

   logic [PW-1:0]                 head_q, tail_q;
   logic                          full, empty, disp_fire, ret_fire;
   logic [DEPTH-1:0]              aval_q;
   logic [DEPTH-1:0][ADDR_W-1:0]  addr_q;
   logic [DEPTH-1:0][DATA_W-1:0]  data_q;
   logic                          head_aval;

   sqf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .disp_valid(disp_valid), .ret_valid(ret_valid),
      .head_q(head_q), .tail_q(tail_q), .full(full), .empty(empty),
      .disp_fire(disp_fire), .ret_fire(ret_fire)
   );

   sqf_slots #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slots (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .disp_fire(disp_fire), .tail_idx(tail_q[IDX_W-1:0]),
      .exe_valid(exe_valid), .exe_idx(exe_idx),
      .exe_addr(exe_addr), .exe_data(exe_data),
      .ret_fire(ret_fire), .head_idx(head_q[IDX_W-1:0]),
      .aval_q(aval_q), .addr_q(addr_q), .data_q(data_q),
      .head_aval(head_aval), .head_addr(wr_addr), .head_data(wr_data)
   );

   sqf_probe #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_probe (
      .clk(clk), .rst_n(rst_n),
      .head_q(head_q), .ld_pos(ld_pos), .ld_addr(ld_addr),
      .aval_q(aval_q), .addr_q(addr_q), .data_q(data_q),
      .hit(ld_hit), .data(ld_data), .unknown(ld_unknown)
   );

   assign disp_ready = !full;
   assign tail_ptr   = tail_q;
   assign sq_empty   = empty;
   assign wr_en      = ret_fire;

   if (CONSERVATIVE) begin : g_cons
      assign ld_ok = !ld_unknown;
      // R9
      cons_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ld_ok |-> !ld_unknown);
   end else begin : g_spec
      assign ld_ok = 1'b1;
   end

   // R4
   ret_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && !sq_empty) |-> head_aval);

   // R4
   wr_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !sq_empty);

endmodule

// File: tb/tb_store_fwd_queue.sv
module tb_store_fwd_queue;

   localparam int D  = 4;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int IW = $clog2(D);
   localparam int PW = IW + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic disp_valid = 1'b0;
   logic exe_valid = 1'b0;
   logic [IW-1:0] exe_idx = '0;
   logic [AW-1:0] exe_addr = '0;
   logic [DW-1:0] exe_data = '0;
   logic ret_valid = 1'b0;
   logic [PW-1:0] ld_pos = '0;
   logic [AW-1:0] ld_addr = '0;

   logic disp_ready, wr_en, sq_empty, ld_hit, ld_unknown, ld_ok;
   logic [PW-1:0] tail_ptr;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data, ld_data;

   logic sp_ready, sp_wr, sp_empty, sp_hit, sp_unknown, sp_ok;
   logic [PW-1:0] sp_tail;
   logic [AW-1:0] sp_waddr;
   logic [DW-1:0] sp_wdata, sp_data;

   always #10 clk = ~clk;

   store_fwd_queue #(.DEPTH(D), .ADDR_W(AW), .DATA_W(DW), .CONSERVATIVE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .disp_valid(disp_valid), .disp_ready(disp_ready), .tail_ptr(tail_ptr),
      .exe_valid(exe_valid), .exe_idx(exe_idx), .exe_addr(exe_addr), .exe_data(exe_data),
      .ret_valid(ret_valid), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sq_empty(sq_empty), .ld_pos(ld_pos), .ld_addr(ld_addr),
      .ld_hit(ld_hit), .ld_data(ld_data), .ld_unknown(ld_unknown), .ld_ok(ld_ok)
   );

   store_fwd_queue #(.DEPTH(D), .ADDR_W(AW), .DATA_W(DW), .CONSERVATIVE(1'b0)) dut_spec (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .disp_valid(disp_valid), .disp_ready(sp_ready), .tail_ptr(sp_tail),
      .exe_valid(exe_valid), .exe_idx(exe_idx), .exe_addr(exe_addr), .exe_data(exe_data),
      .ret_valid(ret_valid), .wr_en(sp_wr), .wr_addr(sp_waddr), .wr_data(sp_wdata),
      .sq_empty(sp_empty), .ld_pos(ld_pos), .ld_addr(ld_addr),
      .ld_hit(sp_hit), .ld_data(sp_data), .ld_unknown(sp_unknown), .ld_ok(sp_ok)
   );

   int n_chk = 0;
   int n_fail = 0;

   // reference model state
   int m_head = 0;
   int m_tail = 0;
   bit m_aval [D];
   int m_addr [D];
   int m_data [D];
   int seq = 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int occ();
      return (m_tail - m_head + 2*D) % (2*D);
   endfunction

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic do_disp();
      bit was_full;
      int t0;
      was_full = (occ() == D);
      t0 = m_tail;
      disp_valid = 1'b1;
      #1;
      chk(tail_ptr == PW'(m_tail), "R2 tail_ptr", int'(tail_ptr), m_tail);
      chk(disp_ready == !was_full, "R2 disp_ready", int'(disp_ready), int'(!was_full));
      step();
      disp_valid = 1'b0;
      if (!was_full) begin
         m_aval[m_tail % D] = 1'b0;
         m_tail = (m_tail + 1) % (2*D);
      end
      #1;
      if (was_full)
         chk(tail_ptr == PW'(t0), "R2 refused dispatch", int'(tail_ptr), t0);
   endtask

   task automatic do_exe(input int idx, input int a, input int dv);
      exe_valid = 1'b1;
      exe_idx = IW'(idx);
      exe_addr = AW'(a);
      exe_data = DW'(dv);
      step();
      exe_valid = 1'b0;
      m_aval[idx] = 1'b1;
      m_addr[idx] = a;
      m_data[idx] = dv;
   endtask

   task automatic do_ret();
      int h;
      h = m_head % D;
      ret_valid = 1'b1;
      #1;
      chk(wr_en == 1'b1, "R4 wr_en", int'(wr_en), 1);
      chk(int'(wr_addr) == m_addr[h], "R4 wr_addr", int'(wr_addr), m_addr[h]);
      chk(int'(wr_data) == m_data[h], "R4 wr_data", int'(wr_data), m_data[h]);
      step();
      ret_valid = 1'b0;
      m_head = (m_head + 1) % (2*D);
   endtask

   task automatic do_probe(input int pos, input int a, input string tag);
      int n;
      bit e_hit, e_unk;
      int e_data;
      n = (pos - m_head + 2*D) % (2*D);
      e_hit = 0;
      e_unk = 0;
      e_data = 0;
      for (int k = 0; k < n; k++) begin
         int p;
         p = (m_head + k) % D;
         if (!m_aval[p]) e_unk = 1;
         else if (m_addr[p] == a) begin
            e_hit = 1;
            e_data = m_data[p];
         end
      end
      ld_pos = PW'(pos);
      ld_addr = AW'(a);
      #1;
      chk(ld_hit == e_hit, {tag, " R5 R7 hit"}, int'(ld_hit), int'(e_hit));
      if (e_hit)
         chk(int'(ld_data) == e_data, {tag, " R6 youngest data"}, int'(ld_data), e_data);
      chk(ld_unknown == e_unk, {tag, " R8 unknown"}, int'(ld_unknown), int'(e_unk));
      chk(ld_ok == !e_unk, {tag, " R9 conservative ok"}, int'(ld_ok), int'(!e_unk));
      chk(sp_ok == 1'b1, {tag, " R9 speculative ok"}, int'(sp_ok), 1);
   endtask

   task automatic probe_all(input string tag);
      for (int o = 0; o <= occ(); o++)
         for (int a = 0; a < 4; a++)
            do_probe((m_head + o) % (2*D), a, tag);
   endtask

   initial begin : watchdog
      #(20 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < D; i++) begin
         m_aval[i] = 0; m_addr[i] = 0; m_data[i] = 0;
      end
      repeat (3) step();
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(sq_empty == 1'b1, "R1 empty", int'(sq_empty), 1);
      chk(disp_ready == 1'b1, "R1 disp_ready", int'(disp_ready), 1);
      chk(tail_ptr == '0, "R1 tail_ptr", int'(tail_ptr), 0);
      chk(wr_en == 1'b0, "R1 wr_en", int'(wr_en), 0);
      chk(ld_hit == 1'b0, "R1 no hit", int'(ld_hit), 0);

      // R11: rounds move the head around the ring several times
      for (int r = 0; r < 12; r++) begin
         int skip;
         while (occ() < D) do_disp();
         do_disp();   // refused while full
         skip = (r % 2 == 1) ? (m_head + (r % D)) % D : -1;
         // execute youngest first, duplicate addresses within a round
         for (int o = D - 1; o >= 0; o--) begin
            int p;
            p = (m_head + o) % D;
            if (!m_aval[p] && p != skip) begin
               do_exe(p, (o + r) % 3, seq);
               seq++;
            end
         end
         probe_all("R11 partial");
         for (int p = 0; p < D; p++)
            if (!m_aval[p]) begin
               do_exe(p, (p + r) % 3, seq);
               seq++;
            end
         probe_all("R11 full");
         for (int k = 0; k <= r % 3; k++) do_ret();
      end

      // R10 flush
      flush = 1'b1;
      step();
      flush = 1'b0;
      m_tail = m_head;
      for (int i = 0; i < D; i++) m_aval[i] = 0;
      #1;
      chk(sq_empty == 1'b1, "R10 empty after flush", int'(sq_empty), 1);
      chk(tail_ptr == PW'(m_head), "R10 tail at head", int'(tail_ptr), m_head);
      chk(disp_ready == 1'b1, "R10 ready after flush", int'(disp_ready), 1);
      do_disp();
      do_probe(m_tail, m_addr[m_head % D], "R10 cleared entry");
      chk(ld_unknown == 1'b1, "R10 entry not executed", int'(ld_unknown), 1);
      do_exe(m_head % D, 2, 16'h7777);
      do_probe(m_tail, 2, "R10 re-executed");
      do_ret();
      #1;
      chk(sq_empty == 1'b1, "R4 drained", int'(sq_empty), 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule